// File: doc/BRIEF.md
# Helper Thread Spawn and Kill Controller

This block manages helper threads on a four-core chip whose cores run speculative threads in a fixed total order. Each cycle it watches the cores that hold speculative threads, the core that holds the most speculative thread, one L2 miss event with a confidence bit from a value predictor, and per-core finish and exception pulses. When the most speculative thread misses in L2 on an address the predictor is confident about, the block clones that thread onto the lowest free core as a helper that runs ahead in runahead mode.

The block tracks each helper and the parent it was cloned from. A helper is killed as soon as its parent stops being the most speculative thread, when the parent or the helper finishes, or when the helper raises an exception. Helper cores are flagged so that violation squashes are neither delivered to them nor issued by them. A helper ends by being thrown away and is never committed.

Spawn and kill commands are combinational on the current inputs and the helper table. The table itself is updated on the next rising clock edge, and the reset is synchronous and active high.

Top module: `htc_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, no core is flagged as a helper, `spawn_vld_o` is 0 and `kill_o` is 0.
- R2: An L2 miss with `miss_conf_i` = 0 never produces a spawn.
- R3: A spawn is issued only when `ms_vld_i` = 1 and `miss_core_i` equals `ms_core_i`. A confident miss from any other core is ignored, and so is one that arrives while the parent core's `fin_i` bit is set.
- R4: A core is free when its `tls_active_i` bit is 0 and it holds no helper. With no free core, no spawn is issued.
- R5: A granted spawn sets `spawn_core_o` to the lowest-numbered free core and `spawn_parent_o` to the miss core. From the next cycle on, that core is flagged as a helper.
- R6: A parent has at most one live helper. A confident miss from a parent that already has a live helper is ignored.
- R7: `kill_o[h]` is raised in the same cycle for a helper core h whose parent is no longer the most speculative thread, either because `ms_vld_i` = 0 or because `ms_core_i` differs from the parent.
- R8: `kill_o[h]` is raised in the same cycle when `fin_i` is set for the parent of h or for h itself, or when `exc_i[h]` is set. Exceptions and finishes on cores that hold no helper kill nothing.
- R9: A killed core stops being flagged on the next clock edge. It is not a spawn target in the cycle of its kill, so a spawn in that cycle goes to another free core.
- R10: `sq_block_o[h]` is 1 exactly while core h holds a live helper, marking it as neither receiving nor issuing squashes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tls_active_i | input | 4 | Per-core flag: core runs a speculative thread |
| ms_vld_i | input | 1 | A most speculative thread exists |
| ms_core_i | input | 2 | Core holding the most speculative thread |
| miss_vld_i | input | 1 | L2 miss event this cycle |
| miss_core_i | input | 2 | Core that took the L2 miss |
| miss_conf_i | input | 1 | Value predictor is confident for the miss address |
| fin_i | input | 4 | Per-core thread finish pulse |
| exc_i | input | 4 | Per-core exception pulse |
| spawn_vld_o | output | 1 | Clone command issued this cycle |
| spawn_core_o | output | 2 | Core that receives the helper |
| spawn_parent_o | output | 2 | Core whose thread is cloned |
| kill_o | output | 4 | Per-core helper kill command |
| sq_block_o | output | 4 | Per-core squash suppression flag (helper live) |

## Verification
A kill and a spawn can happen in the same cycle. When the most speculative thread moves to another core and that core takes a confident miss in that same cycle, the old helper must be killed and the new one spawned at once. The bench provokes this with a free core sitting above the helper being killed, then checks that the helper's own core is passed over as a spawn target and that both table entries hold the expected values one cycle later. Random cycles mix parent changes, finishes and exceptions with confident misses, so kills and spawns keep landing together, and each cycle is compared against a reference model of core ownership.

// File: rtl/htc_pkg.sv
package htc_pkg;

    localparam int unsigned NCORE  = 4;
    localparam int unsigned CIDX_W = $clog2(NCORE);

    typedef logic [CIDX_W-1:0] core_idx_t;
    typedef logic [NCORE-1:0]  core_mask_t;

    typedef struct packed {
        logic      live;
        core_idx_t par;
    } slot_t;

    typedef slot_t [NCORE-1:0] slot_vec_t;

    typedef struct packed {
        logic      vld;
        core_idx_t tgt;
        core_idx_t par;
    } spawn_cmd_t;

    typedef struct packed {
        logic      found;
        core_idx_t idx;
    } pick_t;

    function automatic pick_t lowest_set(core_mask_t m);
        pick_t r;
        r = '0;
        for (int i = NCORE - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.found = 1'b1;
                r.idx   = core_idx_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/htc_kill_eval.sv
module htc_kill_eval
    import htc_pkg::*;
#(
    parameter int unsigned SLOT = 0
) (
    input  slot_t      slot_i,
    input  logic       ms_vld_i,
    input  core_idx_t  ms_core_i,
    input  core_mask_t fin_i,
    input  core_mask_t exc_i,
    output logic       kill_o
);
    localparam core_idx_t SELF = core_idx_t'(SLOT);

    logic parent_lost;
    logic ended;

    always_comb begin
        parent_lost = !ms_vld_i || (ms_core_i != slot_i.par);
        ended       = fin_i[slot_i.par] || fin_i[SELF] || exc_i[SELF];
        kill_o      = slot_i.live && (parent_lost || ended);
    end

endmodule

// File: rtl/htc_spawn_arb.sv
module htc_spawn_arb
    import htc_pkg::*;
(
    input  logic       miss_vld_i,
    input  logic       miss_conf_i,
    input  core_idx_t  miss_core_i,
    input  logic       ms_vld_i,
    input  core_idx_t  ms_core_i,
    input  core_mask_t tls_i,
    input  core_mask_t live_i,
    input  core_mask_t has_helper_i,
    input  core_mask_t fin_i,
    output spawn_cmd_t cmd_o
);
    core_mask_t free_mask;
    pick_t      pick;
    logic       qualified;

    always_comb begin
        free_mask = ~tls_i & ~live_i;
        pick      = lowest_set(free_mask);
        qualified = miss_vld_i && miss_conf_i && ms_vld_i
                 && (miss_core_i == ms_core_i)
                 && !has_helper_i[miss_core_i]
                 && !fin_i[miss_core_i];
        cmd_o.vld = qualified && pick.found;
        cmd_o.tgt = pick.idx;
        cmd_o.par = miss_core_i;
    end

endmodule

// File: rtl/htc_slot_table.sv
module htc_slot_table
    import htc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  spawn_cmd_t spawn_i,
    input  core_mask_t kill_i,
    output slot_vec_t  slots_o
);
    slot_vec_t slots_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else begin
            for (int i = 0; i < NCORE; i++) begin
                if (kill_i[i]) begin
                    slots_q[i].live <= 1'b0;
                end else if (spawn_i.vld && (spawn_i.tgt == core_idx_t'(i))) begin
                    slots_q[i].live <= 1'b1;
                    slots_q[i].par  <= spawn_i.par;
                end
            end
        end
    end

    assign slots_o = slots_q;

    for (genvar g = 0; g < NCORE; g++) begin : g_chk
        a_r9_kill_releases: assert property (@(posedge clk) disable iff (rst)
            kill_i[g] |=> !slots_o[g].live);

        a_r5_spawn_claims: assert property (@(posedge clk) disable iff (rst)
            (spawn_i.vld && spawn_i.tgt == core_idx_t'(g) && !kill_i[g])
            |=> (slots_o[g].live && slots_o[g].par == $past(spawn_i.par)));

        a_r10_slot_holds: assert property (@(posedge clk) disable iff (rst)
            (!kill_i[g] && !(spawn_i.vld && spawn_i.tgt == core_idx_t'(g)))
            |=> (slots_o[g] == $past(slots_o[g])));
    end

endmodule

// File: rtl/htc_ctrl.sv
module htc_ctrl
    import htc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] tls_active_i,
    input  logic             ms_vld_i,
    input  logic [CIDX_W-1:0] ms_core_i,
    input  logic             miss_vld_i,
    input  logic [CIDX_W-1:0] miss_core_i,
    input  logic             miss_conf_i,
    input  logic [NCORE-1:0] fin_i,
    input  logic [NCORE-1:0] exc_i,
    output logic             spawn_vld_o,
    output logic [CIDX_W-1:0] spawn_core_o,
    output logic [CIDX_W-1:0] spawn_parent_o,
    output logic [NCORE-1:0] kill_o,
    output logic [NCORE-1:0] sq_block_o
);
    slot_vec_t  slots;
    core_mask_t live_mask;
    core_mask_t has_helper;
    core_mask_t kill_mask;
    spawn_cmd_t spawn_cmd;

    always_comb begin
        has_helper = '0;
        for (int h = 0; h < NCORE; h++) begin
            live_mask[h] = slots[h].live;
            if (slots[h].live) has_helper[slots[h].par] = 1'b1;
        end
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_kill
        htc_kill_eval #(.SLOT(g)) u_kill (
            .slot_i    (slots[g]),
            .ms_vld_i  (ms_vld_i),
            .ms_core_i (ms_core_i),
            .fin_i     (fin_i),
            .exc_i     (exc_i),
            .kill_o    (kill_mask[g])
        );
    end

    htc_spawn_arb u_arb (
        .miss_vld_i   (miss_vld_i),
        .miss_conf_i  (miss_conf_i),
        .miss_core_i  (miss_core_i),
        .ms_vld_i     (ms_vld_i),
        .ms_core_i    (ms_core_i),
        .tls_i        (tls_active_i),
        .live_i       (live_mask),
        .has_helper_i (has_helper),
        .fin_i        (fin_i),
        .cmd_o        (spawn_cmd)
    );

    htc_slot_table u_tab (
        .clk     (clk),
        .rst     (rst),
        .spawn_i (spawn_cmd),
        .kill_i  (kill_mask),
        .slots_o (slots)
    );

    assign spawn_vld_o    = spawn_cmd.vld;
    assign spawn_core_o   = spawn_cmd.tgt;
    assign spawn_parent_o = spawn_cmd.par;
    assign kill_o         = kill_mask;
    assign sq_block_o     = live_mask;

    a_r2_needs_conf: assert property (@(posedge clk) disable iff (rst)
        spawn_vld_o |-> (miss_vld_i && miss_conf_i));

    a_r3_from_most_spec: assert property (@(posedge clk) disable iff (rst)
        spawn_vld_o |-> (ms_vld_i && spawn_parent_o == ms_core_i && !fin_i[spawn_parent_o]));

    a_r4_target_free: assert property (@(posedge clk) disable iff (rst)
        spawn_vld_o |-> (!tls_active_i[spawn_core_o] && !sq_block_o[spawn_core_o]));

    for (genvar p = 0; p < NCORE; p++) begin : g_par
        core_mask_t kids;
        always_comb begin
            for (int h = 0; h < NCORE; h++)
                kids[h] = slots[h].live && (slots[h].par == core_idx_t'(p));
        end
        a_r6_one_helper: assert property (@(posedge clk) disable iff (rst)
            $onehot0(kids));
    end

    for (genvar h = 0; h < NCORE; h++) begin : g_core
        a_r7_parent_lost: assert property (@(posedge clk) disable iff (rst)
            (sq_block_o[h] && !(ms_vld_i && ms_core_i == slots[h].par)) |-> kill_o[h]);

        a_r8_exception: assert property (@(posedge clk) disable iff (rst)
            (sq_block_o[h] && (exc_i[h] || fin_i[h])) |-> kill_o[h]);

        a_r8_idle_core: assert property (@(posedge clk) disable iff (rst)
            !sq_block_o[h] |-> !kill_o[h]);
    end

endmodule

// File: tb/sim_htc_ctrl.sv
`timescale 1ns/1ps
module sim_htc_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] tls_active_i;
    logic       ms_vld_i;
    logic [1:0] ms_core_i;
    logic       miss_vld_i;
    logic [1:0] miss_core_i;
    logic       miss_conf_i;
    logic [3:0] fin_i;
    logic [3:0] exc_i;
    logic       spawn_vld_o;
    logic [1:0] spawn_core_o;
    logic [1:0] spawn_parent_o;
    logic [3:0] kill_o;
    logic [3:0] sq_block_o;

    always #2.5 clk = ~clk;

    htc_ctrl u0 (.*);

    int checks = 0;
    int failures = 0;

    logic [3:0] ref_help;
    logic [1:0] ref_par [4];
    logic       e_spawn;
    logic [1:0] e_tgt;
    logic [3:0] e_kill;

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic calc();
        logic [3:0] free;
        logic       has;
        e_kill = '0;
        has    = 1'b0;
        for (int h = 0; h < 4; h++) begin
            if (ref_help[h]) begin
                if (!ms_vld_i || ms_core_i != ref_par[h] || fin_i[ref_par[h]]
                    || fin_i[h] || exc_i[h]) e_kill[h] = 1'b1;
                if (ref_par[h] == miss_core_i) has = 1'b1;
            end
        end
        free  = ~tls_active_i & ~ref_help;
        e_tgt = 2'd0;
        for (int i = 3; i >= 0; i--) if (free[i]) e_tgt = 2'(i);
        e_spawn = miss_vld_i && miss_conf_i && ms_vld_i && (miss_core_i == ms_core_i)
               && !has && !fin_i[miss_core_i] && (free != 4'd0);
    endtask

    task automatic idle();
        miss_vld_i = 1'b0; miss_conf_i = 1'b0; miss_core_i = 2'd0;
        fin_i = '0; exc_i = '0;
    endtask

    // called just after a falling edge with inputs set
    task automatic step();
        #1;
        calc();
        chk(sq_block_o == ref_help, "R10 helper flags", 8'(sq_block_o), 8'(ref_help));
        chk(kill_o == e_kill, "R7 R8 kill mask", 8'(kill_o), 8'(e_kill));
        chk(spawn_vld_o == e_spawn, "R5 spawn valid", 8'(spawn_vld_o), 8'(e_spawn));
        if (e_spawn && spawn_vld_o) begin
            chk(spawn_core_o == e_tgt, "R5 spawn core", 8'(spawn_core_o), 8'(e_tgt));
            chk(spawn_parent_o == miss_core_i, "R5 spawn parent",
                8'(spawn_parent_o), 8'(miss_core_i));
        end
        @(posedge clk);
        for (int h = 0; h < 4; h++) begin
            if (e_kill[h]) ref_help[h] = 1'b0;
            else if (e_spawn && e_tgt == 2'(h)) begin
                ref_help[h] = 1'b1;
                ref_par[h]  = miss_core_i;
            end
        end
        @(negedge clk);
    endtask

    task automatic conf_miss(logic [1:0] c);
        miss_vld_i = 1'b1; miss_conf_i = 1'b1; miss_core_i = c;
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7713));
        ref_help = '0;
        for (int i = 0; i < 4; i++) ref_par[i] = 2'd0;
        rst = 1'b1; tls_active_i = '0; ms_vld_i = 1'b0; ms_core_i = 2'd0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: clean state after reset
        chk(sq_block_o == 4'd0, "R1 no helpers", 8'(sq_block_o), 8'd0);
        chk(!spawn_vld_o && kill_o == 4'd0, "R1 no commands",
            8'({spawn_vld_o, kill_o}), 8'd0);
        @(negedge clk);

        tls_active_i = 4'b0011; ms_vld_i = 1'b1; ms_core_i = 2'd1;
        // R2: unconfident miss ignored
        miss_vld_i = 1'b1; miss_conf_i = 1'b0; miss_core_i = 2'd1;
        #1 chk(!spawn_vld_o, "R2 no spawn without confidence", 8'(spawn_vld_o), 8'd0);
        step();
        // R3: miss from a less speculative core ignored
        conf_miss(2'd0);
        #1 chk(!spawn_vld_o, "R3 no spawn from non-most-spec", 8'(spawn_vld_o), 8'd0);
        step();
        // R4: no free core
        tls_active_i = 4'b1111;
        conf_miss(2'd1);
        #1 chk(!spawn_vld_o, "R4 no spawn without free core", 8'(spawn_vld_o), 8'd0);
        step();
        // R5: lowest free core chosen
        tls_active_i = 4'b0011;
        #1 chk(spawn_vld_o && spawn_core_o == 2'd2, "R5 lowest free core",
               8'({spawn_vld_o, spawn_core_o}), 8'h6);
        step();
        idle();
        #1 chk(sq_block_o == 4'b0100, "R10 helper flagged", 8'(sq_block_o), 8'h04);
        step();
        // R6: second confident miss from same parent ignored
        conf_miss(2'd1);
        #1 chk(!spawn_vld_o, "R6 one helper per parent", 8'(spawn_vld_o), 8'd0);
        step();
        // R7 + R9: parent change kills core 2, same-cycle spawn goes to core 3
        ms_core_i = 2'd0;
        conf_miss(2'd0);
        #1 chk(kill_o == 4'b0100, "R7 kill on parent change", 8'(kill_o), 8'h04);
        chk(spawn_vld_o && spawn_core_o == 2'd3, "R9 killed core not reused",
            8'({spawn_vld_o, spawn_core_o}), 8'h7);
        step();
        idle();
        #1 chk(sq_block_o == 4'b1000, "R9 killed core freed", 8'(sq_block_o), 8'h08);
        step();
        // R8: exception on a non-helper core kills nothing; on the helper it kills
        exc_i = 4'b0010;
        #1 chk(kill_o == 4'd0, "R8 exception on tls core ignored", 8'(kill_o), 8'd0);
        step();
        idle();
        exc_i = 4'b1000;
        #1 chk(kill_o == 4'b1000, "R8 kill on helper exception", 8'(kill_o), 8'h08);
        step();
        idle();
        conf_miss(2'd0);
        step();
        idle();
        // R8: parent finish kills helper and blocks spawn that cycle
        fin_i = 4'b0001;
        conf_miss(2'd0);
        #1 chk(kill_o == 4'b0100 && !spawn_vld_o, "R8 kill on parent finish",
               8'({spawn_vld_o, kill_o}), 8'h04);
        step();
        idle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0)
                tls_active_i = 4'($urandom()) & ~ref_help;
            if ($urandom_range(0, 11) == 0) begin
                ms_vld_i  = ($urandom_range(0, 7) != 0);
                ms_core_i = 2'($urandom());
            end
            miss_vld_i  = $urandom_range(0, 1) == 1;
            miss_conf_i = $urandom_range(0, 2) != 0;
            miss_core_i = ($urandom_range(0, 3) != 0) ? ms_core_i : 2'($urandom());
            fin_i = ($urandom_range(0, 19) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'd0;
            exc_i = ($urandom_range(0, 19) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'd0;
            step();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule